// File: doc/BRIEF.md
# Assist Line Buffer for a Direct-Mapped Data Cache

This block is a small, fully associative victim-style line buffer that sits between main memory and a large direct-mapped primary data cache. Every line returned by memory is parked here first. A lookup compares the requested line address against every buffered line and, in the same cycle, against the tag that the primary cache reports for the indexed set. A hit in either place counts as a hit. Several lines that share a primary index can therefore live side by side in the buffer and do not evict one another.

Lines leave the buffer in the order they arrived. Once the buffer is completely occupied, the oldest line is retired. An ordinary line is offered to the primary cache for installation. A line that was touched with the streaming hint is offered back to memory if it was modified, and is discarded silently if it is still clean. Loads and stores that hit in the buffer are served in place. Stores update one word and mark the line modified.

Top module: `assist_cache`

## Requirements
- R1: After reset the buffer is empty: `fill_ready` is 1, `ev_pri_valid` and `ev_mem_valid` are 0, and any request reports `req_miss`.
- R2: A buffered line hits for a request with the same full line address, in the same cycle, no matter which entry holds it. Lines that share the low index bits can coexist. `rd_data` returns word `req_word` of that line, where word k occupies bits [32k+31:32k].
- R3: `pri_index` equals the low 10 bits of `req_line`. `hit_primary` is 1 when `req_valid`, `pri_tag_valid`, and `pri_tag` equal to `req_line[26:10]` all hold. `req_miss` is 1 for a valid request that hits nowhere.
- R4: A fill is taken on a clock edge where `fill_valid` and `fill_ready` are both 1. The line hits from the next cycle on.
- R5: `fill_ready` is 0 exactly when all 64 entries are occupied.
- R6: While the buffer is full, the oldest line is the retirement candidate. `ev_line` and `ev_data` show that line.
- R7: A candidate without the hint is offered on `ev_pri_valid`, whether or not it is modified. The offer holds with stable contents until `ev_pri_ready`. The line is gone after the accepting edge.
- R8: A hinted, modified candidate is offered on `ev_mem_valid` only. A hinted, clean candidate is dropped on the next edge with no offer raised.
- R9: A store hit writes `req_wdata` into the addressed word and marks the line modified. A hit that carries `req_hint` marks the line hinted.
- R10: While a valid request hits the oldest line, no retirement offer is raised and that line is not removed.
- R11: A line that has migrated to the primary cache hits only there; `hit_assist` and `hit_primary` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load/store lookup request |
| req_store | input | 1 | Request is a store |
| req_hint | input | 1 | Streaming (use-once) hint on the access |
| req_line | input | 27 | Requested line address |
| req_word | input | 3 | Word select inside the line |
| req_wdata | input | 32 | Store data |
| pri_index | output | 10 | Set index sent to the primary tag array |
| pri_tag_valid | input | 1 | Primary entry at that set is valid |
| pri_tag | input | 17 | Primary tag at that set |
| hit_assist | output | 1 | Hit in the line buffer |
| hit_primary | output | 1 | Hit in the primary cache |
| req_miss | output | 1 | Valid request hit nowhere |
| rd_data | output | 32 | Selected word of the buffer hit, 0 otherwise |
| fill_valid | input | 1 | Line arriving from memory |
| fill_hint | input | 1 | Arriving line carries the streaming hint |
| fill_line | input | 27 | Address of arriving line |
| fill_data | input | 256 | Contents of arriving line |
| fill_ready | output | 1 | Buffer can take a line |
| ev_pri_valid | output | 1 | Oldest line offered to primary cache |
| ev_pri_ready | input | 1 | Primary cache takes the offer |
| ev_mem_valid | output | 1 | Oldest line offered for write-back to memory |
| ev_mem_ready | input | 1 | Memory takes the offer |
| ev_line | output | 27 | Address of the oldest line |
| ev_data | output | 256 | Contents of the oldest line |

## Verification
The hardest situations to reach are those that need a completely occupied buffer whose oldest entry has a chosen mix of hint and modified state. Each retirement route has to be seen in turn, and so does a lookup that lands on that oldest entry while an offer is pending. The stimulus loads four same-index lines with distinct hint and store histories, then pads the buffer with sixty filler lines while both acceptors are held off. After that, single fills re-fill the freed slot one at a time. Each fill brings the next crafted line to the head, so the primary, silent-drop and memory routes are observed in a known order.

// File: rtl/assist_cache_pkg.sv
package assist_cache_pkg;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic hint;
  } ac_flags_t;

  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_PRI  = 2'd1,
    RET_MEM  = 2'd2,
    RET_DROP = 2'd3
  } ac_retire_e;

  // Destination of a retiring line from its status bits.
  function automatic ac_retire_e ac_route(input ac_flags_t f);
    if (!f.valid)     return RET_NONE;
    else if (!f.hint) return RET_PRI;
    else if (f.dirty) return RET_MEM;
    else              return RET_DROP;
  endfunction

endpackage

// File: rtl/ac_fifo_ptr.sv
module ac_fifo_ptr #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [OCC_W-1:0] occ,
  output logic             full
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push) tail_q <= step(tail_q);
      if (pop)  head_q <= step(head_q);
      if (push && !pop)      occ_q <= occ_q + OCC_W'(1);
      else if (pop && !push) occ_q <= occ_q - OCC_W'(1);
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign occ  = occ_q;
  assign full = (occ_q == OCC_W'(DEPTH));

endmodule

// File: rtl/ac_match.sv
module ac_match #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 27,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] lines [DEPTH],
  input  logic [DEPTH-1:0]  valids,
  input  logic [ADDR_W-1:0] key,
  output logic [DEPTH-1:0]  hit_vec,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_idx
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = valids[g] && (lines[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = PTR_W'(i);
    end
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/ac_store.sv
module ac_store
  import assist_cache_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 27,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  logic [ADDR_W-1:0] alloc_line,
  input  logic [LINE_W-1:0] alloc_data,
  input  logic              alloc_hint,
  input  logic              acc_en,
  input  logic [PTR_W-1:0]  acc_idx,
  input  logic              acc_store,
  input  logic              acc_hint,
  input  logic [WSEL_W-1:0] acc_word,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              free_en,
  input  logic [PTR_W-1:0]  peek_idx,
  output logic [ADDR_W-1:0] lines [DEPTH],
  output logic [DEPTH-1:0]  valids,
  output logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] peek_line,
  output logic [LINE_W-1:0] peek_data,
  output ac_flags_t         peek_flags
);

  logic [DEPTH-1:0]  valid_q, dirty_q, hint_q;
  logic [ADDR_W-1:0] line_q [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      hint_q  <= '0;
    end else begin
      if (free_en) valid_q[peek_idx] <= 1'b0;
      if (acc_en) begin
        hint_q[acc_idx] <= hint_q[acc_idx] | acc_hint;
        if (acc_store) dirty_q[acc_idx] <= 1'b1;
      end
      if (alloc_en) begin
        valid_q[alloc_idx] <= 1'b1;
        dirty_q[alloc_idx] <= 1'b0;
        hint_q[alloc_idx]  <= alloc_hint;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line_q[alloc_idx] <= alloc_line;
      data_q[alloc_idx] <= alloc_data;
    end
    if (acc_en && acc_store)
      data_q[acc_idx][acc_word*WORD_W +: WORD_W] <= acc_wdata;
  end

  assign lines      = line_q;
  assign valids     = valid_q;
  assign rd_word    = data_q[acc_idx][acc_word*WORD_W +: WORD_W];
  assign peek_line  = line_q[peek_idx];
  assign peek_data  = data_q[peek_idx];
  assign peek_flags = '{valid: valid_q[peek_idx], dirty: dirty_q[peek_idx],
                        hint: hint_q[peek_idx]};

endmodule

// File: rtl/assist_cache.sv
module assist_cache
  import assist_cache_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int DEPTH     = 64,
  parameter int LINE_W    = 256,
  parameter int WORD_W    = 32,
  parameter int PRI_IDX_W = 10,
  localparam int TAG_W  = ADDR_W - PRI_IDX_W,
  localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_hint,
  input  logic [ADDR_W-1:0] req_line,
  input  logic [WSEL_W-1:0] req_word,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [PRI_IDX_W-1:0] pri_index,
  input  logic              pri_tag_valid,
  input  logic [TAG_W-1:0]  pri_tag,
  output logic              hit_assist,
  output logic              hit_primary,
  output logic              req_miss,
  output logic [WORD_W-1:0] rd_data,
  input  logic              fill_valid,
  input  logic              fill_hint,
  input  logic [ADDR_W-1:0] fill_line,
  input  logic [LINE_W-1:0] fill_data,
  output logic              fill_ready,
  output logic              ev_pri_valid,
  input  logic              ev_pri_ready,
  output logic              ev_mem_valid,
  input  logic              ev_mem_ready,
  output logic [ADDR_W-1:0] ev_line,
  output logic [LINE_W-1:0] ev_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  function automatic logic [PRI_IDX_W-1:0] index_of(input logic [ADDR_W-1:0] l);
    return l[PRI_IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] l);
    return l[ADDR_W-1:PRI_IDX_W];
  endfunction

  // Named internal events, visible to the bound checker.
  logic              push, pop, full, head_blocked;
  logic [PTR_W-1:0]  head, tail, a_idx;
  logic [OCC_W-1:0]  occ;
  logic [DEPTH-1:0]  a_hit_vec, st_valids;
  logic              a_hit;
  logic [ADDR_W-1:0] st_lines [DEPTH];
  logic [WORD_W-1:0] st_rd_word;
  ac_flags_t         head_flags;
  ac_retire_e        retire_kind;

  ac_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .occ(occ), .full(full)
  );

  ac_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .lines(st_lines), .valids(st_valids), .key(req_line),
    .hit_vec(a_hit_vec), .hit(a_hit), .hit_idx(a_idx)
  );

  ac_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(push), .alloc_idx(tail), .alloc_line(fill_line),
    .alloc_data(fill_data), .alloc_hint(fill_hint),
    .acc_en(hit_assist), .acc_idx(a_idx), .acc_store(req_store),
    .acc_hint(req_hint), .acc_word(req_word), .acc_wdata(req_wdata),
    .free_en(pop), .peek_idx(head),
    .lines(st_lines), .valids(st_valids), .rd_word(st_rd_word),
    .peek_line(ev_line), .peek_data(ev_data), .peek_flags(head_flags)
  );

  // Lookup across the buffer and the indexed primary entry.
  assign pri_index   = index_of(req_line);
  assign hit_assist  = req_valid && a_hit;
  assign hit_primary = req_valid && pri_tag_valid && (pri_tag == tag_of(req_line));
  assign req_miss    = req_valid && !hit_assist && !hit_primary;
  assign rd_data     = hit_assist ? st_rd_word : '0;

  // Retirement of the oldest line once every entry is taken.
  assign head_blocked = hit_assist && (a_idx == head);
  assign retire_kind  = (full && !head_blocked) ? ac_route(head_flags) : RET_NONE;
  assign ev_pri_valid = (retire_kind == RET_PRI);
  assign ev_mem_valid = (retire_kind == RET_MEM);
  assign pop = (retire_kind == RET_DROP) ||
               (ev_pri_valid && ev_pri_ready) ||
               (ev_mem_valid && ev_mem_ready);

  assign fill_ready = !full;
  assign push       = fill_valid && fill_ready;

endmodule

// File: rtl/assist_cache_checker.sv
module assist_cache_checker #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 27,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              hit_assist,
  input logic              hit_primary,
  input logic              req_miss,
  input logic              fill_ready,
  input logic              push,
  input logic              pop,
  input logic              full,
  input logic [OCC_W-1:0]  occ,
  input logic              ev_pri_valid,
  input logic              ev_pri_ready,
  input logic              ev_mem_valid,
  input logic              head_blocked,
  input logic [ADDR_W-1:0] ev_line
);

  assert_no_dual_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_assist && hit_primary));

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_assist, hit_primary, req_miss}) &&
    (req_valid == (hit_assist || hit_primary || req_miss)));

  assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_fill_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> occ == OCC_W'($past(occ) + OCC_W'(1)));

  assert_retire_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> occ == OCC_W'($past(occ) - OCC_W'(1)));

  assert_offer_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pri_valid || ev_mem_valid) |-> (full && !fill_ready));

  assert_single_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_pri_valid, ev_mem_valid}));

  assert_head_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    head_blocked |-> (!ev_pri_valid && !ev_mem_valid && !pop));

  assert_pri_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pri_valid && !ev_pri_ready |=> $stable(ev_line) && (ev_pri_valid || head_blocked));

endmodule

bind assist_cache assist_cache_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit_assist(hit_assist),
  .hit_primary(hit_primary), .req_miss(req_miss), .fill_ready(fill_ready),
  .push(push), .pop(pop), .full(full), .occ(occ),
  .ev_pri_valid(ev_pri_valid), .ev_pri_ready(ev_pri_ready),
  .ev_mem_valid(ev_mem_valid), .head_blocked(head_blocked), .ev_line(ev_line)
);

// File: tb/assist_cache_bench.sv
module assist_cache_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 0, req_store = 0, req_hint = 0;
  logic [26:0]  req_line = '0;
  logic [2:0]   req_word = '0;
  logic [31:0]  req_wdata = '0;
  logic [9:0]   pri_index;
  logic         pri_tag_valid = 0;
  logic [16:0]  pri_tag = '0;
  logic         hit_assist, hit_primary, req_miss;
  logic [31:0]  rd_data;
  logic         fill_valid = 0, fill_hint = 0;
  logic [26:0]  fill_line = '0;
  logic [255:0] fill_data = '0;
  logic         fill_ready;
  logic         ev_pri_valid, ev_mem_valid;
  logic         ev_pri_ready = 0, ev_mem_ready = 0;
  logic [26:0]  ev_line;
  logic [255:0] ev_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  localparam logic [26:0] LA = 27'h0000123;
  localparam logic [26:0] LB = 27'h4000123;
  localparam logic [26:0] LC = 27'h2000123;
  localparam logic [26:0] LG = 27'h1000123;
  localparam logic [26:0] LD = 27'h3000123;
  localparam logic [26:0] LE = 27'h5000123;
  localparam logic [26:0] LF = 27'h6000123;

  always #2.5 clk = ~clk;

  assist_cache u_assist_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_hint(req_hint), .req_line(req_line), .req_word(req_word),
    .req_wdata(req_wdata), .pri_index(pri_index), .pri_tag_valid(pri_tag_valid),
    .pri_tag(pri_tag), .hit_assist(hit_assist), .hit_primary(hit_primary),
    .req_miss(req_miss), .rd_data(rd_data), .fill_valid(fill_valid),
    .fill_hint(fill_hint), .fill_line(fill_line), .fill_data(fill_data),
    .fill_ready(fill_ready), .ev_pri_valid(ev_pri_valid), .ev_pri_ready(ev_pri_ready),
    .ev_mem_valid(ev_mem_valid), .ev_mem_ready(ev_mem_ready),
    .ev_line(ev_line), .ev_data(ev_data)
  );

  function automatic logic [31:0] word_of(input logic [26:0] l, input int k);
    return ({5'd0, l} << 3) + 32'(k) ^ 32'hA500_0000;
  endfunction

  function automatic logic [255:0] line_of(input logic [26:0] l);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = word_of(l, k);
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [26:0] l, input logic h, input logic [255:0] d);
    @(negedge clk);
    fill_valid = 1; fill_hint = h; fill_line = l; fill_data = d;
    @(negedge clk);
    fill_valid = 0; fill_hint = 0;
  endtask

  // Drive a request at a falling edge, sample mid-cycle, hold through the rising edge.
  task automatic probe(input logic [26:0] l, input logic st, input logic h,
                       input logic [2:0] w, input logic [31:0] wd,
                       output logic ha, output logic hp, output logic ms,
                       output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_store = st; req_hint = h; req_line = l;
    req_word = w; req_wdata = wd;
    #1;
    ha = hit_assist; hp = hit_primary; ms = req_miss; rd = rd_data;
    @(negedge clk);
    req_valid = 0; req_store = 0; req_hint = 0;
  endtask

  task automatic t_reset;
    logic ha, hp, ms; logic [31:0] rd;
    chk("R1", "fill_ready", 256'(fill_ready), 256'(1));
    chk("R1", "ev_pri_valid", 256'(ev_pri_valid), 256'(0));
    chk("R1", "ev_mem_valid", 256'(ev_mem_valid), 256'(0));
    probe(LA, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R1", "miss after reset", 256'({ha, ms}), 256'(2'b01));
  endtask

  task automatic t_primary;
    logic ha, hp, ms; logic [31:0] rd;
    pri_tag_valid = 1; pri_tag = LA[26:10];
    @(negedge clk);
    req_valid = 1; req_line = LA; #1;
    chk("R3", "pri_index", 256'(pri_index), 256'(LA[9:0]));
    chk("R3", "primary hit", 256'({hit_primary, req_miss}), 256'(2'b10));
    @(negedge clk); req_valid = 0;
    pri_tag = LB[26:10];
    probe(LA, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R3", "tag mismatch misses", 256'({hp, ms}), 256'(2'b01));
    pri_tag_valid = 0;
  endtask

  task automatic t_fill_lookup;
    logic ha, hp, ms; logic [31:0] rd;
    fill(LA, 0, line_of(LA));
    fill(LB, 1, line_of(LB));
    fill(LC, 1, line_of(LC));
    fill(LG, 0, line_of(LG));
    probe(LA, 0, 0, 3'd2, 0, ha, hp, ms, rd);
    chk("R4", "first fill hits", 256'(ha), 256'(1));
    chk("R2", "word 2 of A", 256'(rd), 256'(word_of(LA, 2)));
    probe(LB, 0, 0, 3'd7, 0, ha, hp, ms, rd);
    chk("R2", "same index line B word 7", 256'({ha, rd}), 256'({1'b1, word_of(LB, 7)}));
    probe(LG, 0, 0, 3'd0, 0, ha, hp, ms, rd);
    chk("R2", "same index line G word 0", 256'({ha, rd}), 256'({1'b1, word_of(LG, 0)}));
  endtask

  task automatic t_store;
    logic ha, hp, ms; logic [31:0] rd;
    probe(LC, 1, 0, 3'd5, 32'hDEAD_0005, ha, hp, ms, rd);
    probe(LG, 1, 1, 3'd0, 32'h0BAD_0000, ha, hp, ms, rd);
    probe(LC, 0, 0, 3'd5, 0, ha, hp, ms, rd);
    chk("R9", "store word readback", 256'(rd), 256'(32'hDEAD_0005));
    probe(LC, 0, 0, 3'd4, 0, ha, hp, ms, rd);
    chk("R9", "neighbour word untouched", 256'(rd), 256'(word_of(LC, 4)));
  endtask

  task automatic t_full_pri;
    logic ha, hp, ms; logic [31:0] rd;
    for (int i = 0; i < 60; i++) begin
      if (i == 59) chk("R5", "ready with 63 held", 256'(fill_ready), 256'(1));
      fill(27'h0010000 + 27'(i), 0, line_of(27'h0010000 + 27'(i)));
    end
    #1;
    chk("R5", "not ready when full", 256'(fill_ready), 256'(0));
    chk("R7", "offer to primary", 256'({ev_pri_valid, ev_mem_valid}), 256'(2'b10));
    chk("R6", "oldest line offered", 256'(ev_line), 256'(LA));
    chk("R6", "oldest data offered", ev_data, line_of(LA));
    repeat (3) @(negedge clk);
    #1;
    chk("R7", "offer held", 256'({ev_pri_valid, ev_line}), 256'({1'b1, LA}));
    @(negedge clk);
    req_valid = 1; req_line = LA; req_word = 0; #1;
    chk("R10", "offer withdrawn on head hit", 256'({hit_assist, ev_pri_valid}), 256'(2'b10));
    @(negedge clk); req_valid = 0; #1;
    chk("R10", "head kept", 256'({ev_pri_valid, ev_line}), 256'({1'b1, LA}));
    @(negedge clk); ev_pri_ready = 1;
    @(negedge clk); ev_pri_ready = 0; #1;
    chk("R7", "offer cleared after accept", 256'({ev_pri_valid, fill_ready}), 256'(2'b01));
    probe(LA, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R7", "retired line gone", 256'({ha, ms}), 256'(2'b01));
    pri_tag_valid = 1; pri_tag = LA[26:10];
    probe(LA, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R11", "migrated line hits primary only", 256'({ha, hp}), 256'(2'b01));
    pri_tag_valid = 0;
  endtask

  task automatic t_drop;
    logic ha, hp, ms; logic [31:0] rd;
    fill(LD, 0, line_of(LD));
    #1;
    chk("R8", "clean hinted no offer",
        256'({fill_ready, ev_pri_valid, ev_mem_valid}), 256'(3'b000));
    @(negedge clk); #1;
    chk("R8", "slot freed by drop", 256'(fill_ready), 256'(1));
    probe(LB, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R8", "dropped line gone", 256'({ha, ms}), 256'(2'b01));
  endtask

  task automatic t_mem;
    logic ha, hp, ms; logic [31:0] rd;
    logic [255:0] expd;
    fill(LE, 0, line_of(LE));
    #1;
    expd = line_of(LC); expd[5*32 +: 32] = 32'hDEAD_0005;
    chk("R8", "dirty hinted to memory", 256'({ev_pri_valid, ev_mem_valid}), 256'(2'b01));
    chk("R8", "memory offer line", 256'(ev_line), 256'(LC));
    chk("R9", "stored word written back", ev_data, expd);
    @(negedge clk); ev_mem_ready = 1;
    @(negedge clk); ev_mem_ready = 0;
    probe(LC, 0, 0, 0, 0, ha, hp, ms, rd);
    chk("R8", "written-back line gone", 256'({ha, ms}), 256'(2'b01));
    fill(LF, 0, line_of(LF));
    #1;
    expd = line_of(LG); expd[31:0] = 32'h0BAD_0000;
    chk("R9", "hint on hit reroutes", 256'({ev_pri_valid, ev_mem_valid, ev_line}),
        256'({2'b01, LG}));
    chk("R9", "hinted store data", ev_data, expd);
    @(negedge clk); ev_mem_ready = 1;
    @(negedge clk); ev_mem_ready = 0;
    probe(LD, 0, 0, 3'd1, 0, ha, hp, ms, rd);
    chk("R2", "later line still hits", 256'({ha, rd}), 256'({1'b1, word_of(LD, 1)}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_primary();
    t_fill_lookup();
    t_store();
    t_full_pri();
    t_drop();
    t_mem();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule